// File: doc/BRIEF.md
# Twenty-Four Line Parallel Port Controller

This block gives a host simple, handshake-free control over twenty-four general purpose lines. The lines form four direction groups: two full byte ports, called A and B, and a third byte port, C, whose lower and upper nibbles are directed separately. The host reaches everything through a four-location register window. Three locations carry port data, and the fourth takes a direction word.

Each group holds an output latch. A host write always lands in the latch, even while the group is an input. A group's pin drivers come on only when two conditions hold: the group is set to output, and its port has been written at least once since reset. Software can therefore load safe output values first and switch direction afterwards, and no line drives an undefined level. Port reads are not latched. They sample the pins at the moment of the access, so a group that is driving reads back the level actually present on its pins.

Host accesses use a one-cycle strobe. Read data appears on the cycle after the strobe, together with a one-cycle valid pulse. The pins are modelled as three separate vectors: pad input, pad output and per-line output enable. Pin bits 7:0 belong to port A, 15:8 to port B, and 23:16 to port C, with C's lower nibble on 19:16.

Top module: `pio24_ctrl`

## Requirements
- R1: After reset every output enable is 0, every output latch is 0, the read-valid flag is 0, and all four groups are inputs.
- R2: A write at offset 0, 1 or 2 loads the latch of port A, B or C from the write data in every direction state. A port C write loads its lower nibble from data bits 3:0 and its upper nibble from bits 7:4. The pad output vector always presents the latch contents.
- R3: A write at offset 3 with bit 7 set loads the directions. Bit 4 sets port A, bit 1 sets port B, bit 0 sets the lower nibble of C and bit 3 sets the upper nibble of C, with 1 meaning input and 0 meaning output. The word 0x80 makes all groups outputs and 0x9B makes all groups inputs.
- R4: A write at offset 3 with bit 7 clear is ignored and leaves all directions unchanged.
- R5: A group drives its lines (enables all 1) only while it is an output and its port has received at least one data write since reset. Otherwise its enables are 0.
- R6: A read strobe raises the valid flag for exactly the following cycle. The read data then holds the pin values sampled at the strobe, so two reads of an input see any change of the pins between them.
- R7: A read at offset 3 returns 0xFF.
- R8: A port C read takes each nibble from its own pins, so a driving nibble returns its latch value and an input nibble returns the external level at the same time.
- R9: A write at offset 3 never changes any data latch, writes produce no read-valid pulse, and the output enables change only on cycles after a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| acc_en | input | 1 | One-cycle access strobe |
| acc_wr | input | 1 | Access is a write when 1, a read when 0 |
| acc_addr | input | 2 | Register offset: 0 port A, 1 port B, 2 port C, 3 direction word |
| acc_wdata | input | 8 | Write data |
| acc_rdata | output | 8 | Read data, valid with acc_rvalid |
| acc_rvalid | output | 1 | High on the cycle after a read strobe |
| pin_i | input | 24 | Level present on the pads |
| pin_o | output | 24 | Output latch values toward the pads |
| pin_oe | output | 24 | Per-line output enable |

## Verification
The direction word is exercised with all-output, all-input, a word lacking the enable bit, and words that flip a single group. This distinguishes the bit position of each group and shows that the enable bit gates the update. Data writes go to a group while it is an input and again while it is an output, so that the rule "drive only after a write" can be told apart from "drive as soon as set to output". Port C is read with its nibbles pointed in opposite directions, both ways round. This shows that each nibble is taken from its own pins. Repeated reads of an input while the external pattern changes show that no read data is held over between accesses.

// File: rtl/pio24_pkg.sv
package pio24_pkg;
  localparam int NGRP         = 4;   // A, B, C-low, C-high
  localparam int CFG_LOAD_BIT = 7;

  localparam logic [1:0] OFS_A   = 2'd0;
  localparam logic [1:0] OFS_B   = 2'd1;
  localparam logic [1:0] OFS_C   = 2'd2;
  localparam logic [1:0] OFS_CFG = 2'd3;

  // direction bit in the configuration word for each group
  function automatic int grp_cfg_bit(input int g);
    case (g)
      0:       return 4;
      1:       return 1;
      2:       return 0;
      default: return 3;
    endcase
  endfunction

  function automatic logic [1:0] grp_ofs(input int g);
    case (g)
      0:       return OFS_A;
      1:       return OFS_B;
      default: return OFS_C;
    endcase
  endfunction

  function automatic int grp_width(input int g, input int dw);
    return (g < 2) ? dw : dw / 2;
  endfunction

  function automatic int grp_pin_lo(input int g, input int dw);
    case (g)
      0:       return 0;
      1:       return dw;
      2:       return 2 * dw;
      default: return 2 * dw + dw / 2;
    endcase
  endfunction

  function automatic int grp_data_lo(input int g, input int dw);
    return (g == 3) ? dw / 2 : 0;
  endfunction
endpackage

// File: rtl/pio24_cfg.sv
module pio24_cfg
  import pio24_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [DW-1:0]   cfg_wdata,
  output logic [NGRP-1:0] dir_in
);
  logic [NGRP-1:0] dir_d;
  logic            load_en;
  logic            unused_cfg;

  assign unused_cfg = ^cfg_wdata;

  always_comb begin
    load_en = cfg_we & cfg_wdata[CFG_LOAD_BIT];
    for (int g = 0; g < NGRP; g++) begin
      dir_d[g] = cfg_wdata[grp_cfg_bit(g)];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_in <= '1;
    end else if (load_en) begin
      dir_in <= dir_d;
    end
  end
endmodule

// File: rtl/pio24_group.sv
module pio24_group #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] wd,
  input  logic         dir_in,
  output logic [W-1:0] q,
  output logic [W-1:0] oe
);
  logic [W-1:0] lat_q, lat_d;
  logic         armed_q, armed_d;

  always_comb begin
    lat_d   = we ? wd : lat_q;
    armed_d = armed_q | we;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q   <= '0;
      armed_q <= 1'b0;
    end else if (we) begin
      lat_q   <= lat_d;
      armed_q <= armed_d;
    end
  end

  assign q  = lat_q;
  assign oe = {W{armed_q & ~dir_in}};
endmodule

// File: rtl/pio24_rdport.sv
module pio24_rdport
  import pio24_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_en,
  input  logic [1:0]    addr,
  input  logic [3*DW-1:0] pins,
  output logic [DW-1:0] rdata,
  output logic          rvalid
);
  logic [DW-1:0] sel_d;

  always_comb begin
    case (addr)
      OFS_A:   sel_d = pins[DW-1:0];
      OFS_B:   sel_d = pins[2*DW-1:DW];
      OFS_C:   sel_d = pins[3*DW-1:2*DW];
      default: sel_d = '1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= rd_en;
      if (rd_en) begin
        rdata <= sel_d;
      end
    end
  end
endmodule

// File: rtl/pio24_ctrl.sv
module pio24_ctrl
  import pio24_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            acc_en,
  input  logic            acc_wr,
  input  logic [1:0]      acc_addr,
  input  logic [DW-1:0]   acc_wdata,
  output logic [DW-1:0]   acc_rdata,
  output logic            acc_rvalid,
  input  logic [3*DW-1:0] pin_i,
  output logic [3*DW-1:0] pin_o,
  output logic [3*DW-1:0] pin_oe
);
  logic [1:0]      rst_sync;
  logic            rst_ni;
  logic            wr_stb, rd_stb;
  logic [NGRP-1:0] dir_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync <= '0;
    end else begin
      rst_sync <= {rst_sync[0], 1'b1};
    end
  end
  assign rst_ni = rst_sync[1];

  assign wr_stb = acc_en &  acc_wr;
  assign rd_stb = acc_en & ~acc_wr;

  pio24_cfg #(.DW(DW)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_ni),
    .cfg_we    (wr_stb && (acc_addr == OFS_CFG)),
    .cfg_wdata (acc_wdata),
    .dir_in    (dir_in)
  );

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    localparam int         W  = grp_width(g, DW);
    localparam int         PL = grp_pin_lo(g, DW);
    localparam int         DL = grp_data_lo(g, DW);
    localparam logic [1:0] OF = grp_ofs(g);

    pio24_group #(.W(W)) u_grp (
      .clk    (clk),
      .rst_n  (rst_ni),
      .we     (wr_stb && (acc_addr == OF)),
      .wd     (acc_wdata[DL+W-1:DL]),
      .dir_in (dir_in[g]),
      .q      (pin_o[PL+W-1:PL]),
      .oe     (pin_oe[PL+W-1:PL])
    );
  end

  pio24_rdport #(.DW(DW)) u_rd (
    .clk    (clk),
    .rst_n  (rst_ni),
    .rd_en  (rd_stb),
    .addr   (acc_addr),
    .pins   (pin_i),
    .rdata  (acc_rdata),
    .rvalid (acc_rvalid)
  );
endmodule

// File: rtl/pio24_ctrl_chk.sv
module pio24_ctrl_chk #(
  parameter int DW = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            acc_en,
  input logic            acc_wr,
  input logic [1:0]      acc_addr,
  input logic [DW-1:0]   acc_wdata,
  input logic [DW-1:0]   acc_rdata,
  input logic            acc_rvalid,
  input logic [3*DW-1:0] pin_i,
  input logic [3*DW-1:0] pin_o,
  input logic [3*DW-1:0] pin_oe
);
  logic rd_s, wr_s;
  assign rd_s = acc_en & ~acc_wr;
  assign wr_s = acc_en &  acc_wr;

  // R6: valid pulse follows every read strobe
  a_r6_valid_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_s |=> acc_rvalid);

  // R6 and R9: no valid pulse without a read strobe
  a_r6_no_stray_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_s |=> !acc_rvalid);

  // R6: read data is the pin sample taken at the strobe
  a_r6_port_a_sample: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_s && acc_addr == 2'd0) |=> acc_rdata == $past(pin_i[DW-1:0]));

  // R7
  a_r7_cfg_reads_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_s && acc_addr == 2'd3) |=> acc_rdata == {DW{1'b1}});

  // R2
  a_r2_port_b_latch: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_s && acc_addr == 2'd1) |=> pin_o[2*DW-1:DW] == $past(acc_wdata));

  // R4
  a_r4_unloaded_cfg_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_s && acc_addr == 2'd3 && !acc_wdata[7]) |=> $stable(pin_oe));

  // R9
  a_r9_oe_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_s |=> $stable(pin_oe));

  // R9
  a_r9_cfg_keeps_latches: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_s && acc_addr == 2'd3) |=> $stable(pin_o));
endmodule

bind pio24_ctrl pio24_ctrl_chk #(.DW(DW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .acc_en     (acc_en),
  .acc_wr     (acc_wr),
  .acc_addr   (acc_addr),
  .acc_wdata  (acc_wdata),
  .acc_rdata  (acc_rdata),
  .acc_rvalid (acc_rvalid),
  .pin_i      (pin_i),
  .pin_o      (pin_o),
  .pin_oe     (pin_oe)
);

// File: tb/pio24_ctrl_test.sv
module pio24_ctrl_test;
  localparam int DW = 8;
  localparam int PW = 3 * DW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          acc_en = 1'b0;
  logic          acc_wr = 1'b0;
  logic [1:0]    acc_addr = '0;
  logic [DW-1:0] acc_wdata = '0;
  logic [DW-1:0] acc_rdata;
  logic          acc_rvalid;
  logic [PW-1:0] ext = '0;
  logic [PW-1:0] pin_i, pin_o, pin_oe;

  int  n_checks = 0;
  int  n_fail   = 0;
  bit  done     = 1'b0;

  logic [DW-1:0] exp_q[$];
  string         tag_q[$];

  always #10 clk = ~clk;

  // pads: driven lines show the latch, the rest follow the outside world
  assign pin_i = (pin_o & pin_oe) | (ext & ~pin_oe);

  pio24_ctrl #(.DW(DW)) uut (
    .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_wr(acc_wr),
    .acc_addr(acc_addr), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
    .acc_rvalid(acc_rvalid), .pin_i(pin_i), .pin_o(pin_o), .pin_oe(pin_oe)
  );

  task automatic check(input string tag, input logic [PW-1:0] act, input logic [PW-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    acc_en = 1'b1; acc_wr = 1'b1; acc_addr = a; acc_wdata = d;
    @(negedge clk);
    acc_en = 1'b0; acc_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, input logic [DW-1:0] exp, input string tag);
    @(negedge clk);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    acc_en = 1'b1; acc_wr = 1'b0; acc_addr = a;
    @(negedge clk);
    acc_en = 1'b0;
    @(negedge clk);
  endtask

  // monitor: pops the scoreboard when the design presents read data
  always @(negedge clk) begin
    if (rst_n && acc_rvalid) begin
      if (exp_q.size() == 0) begin
        n_checks++; n_fail++;
        $display("FAIL R9: valid pulse with nothing expected, actual %h expected none", acc_rdata);
      end else begin
        logic [DW-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, PW'(acc_rdata), PW'(e));
      end
    end
  end

  initial begin
    ext = 24'hC3965A;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    check("R1 oe after reset", pin_oe, '0);
    check("R1 latches after reset", pin_o, '0);
    check("R1 rvalid after reset", PW'(acc_rvalid), '0);

    bus_read(2'd0, 8'h5A, "R6 read A input");
    bus_read(2'd1, 8'h96, "R6 read B input");
    bus_read(2'd2, 8'hC3, "R8 read C input");
    bus_read(2'd3, 8'hFF, "R7 read cfg");

    bus_write(2'd0, 8'h11);
    check("R5 A written while input", pin_oe, '0);
    check("R2 A latch preload", pin_o, 24'h000011);

    bus_write(2'd3, 8'h00);
    check("R4 cfg without load bit", pin_oe, '0);

    bus_write(2'd3, 8'h80);
    check("R5 only written A drives", pin_oe, 24'h0000FF);
    bus_read(2'd0, 8'h11, "R8 A readback");

    bus_write(2'd1, 8'h22);
    check("R5 B drives after write", pin_oe, 24'h00FFFF);
    check("R2 B latch", pin_o, 24'h002211);
    bus_read(2'd1, 8'h22, "R8 B readback");

    bus_write(2'd3, 8'h9B);
    check("R3 all input", pin_oe, '0);
    check("R9 cfg keeps latches", pin_o, 24'h002211);
    bus_read(2'd0, 8'h5A, "R6 A back to pins");

    bus_write(2'd3, 8'h89);
    check("R3 C both halves input", pin_oe, 24'h00FFFF);
    bus_write(2'd2, 8'hA5);
    check("R2 C latch both nibbles", pin_o, 24'hA52211);
    check("R5 C input after write", pin_oe, 24'h00FFFF);

    bus_write(2'd3, 8'h88);
    check("R3 C low out high in", pin_oe, 24'h0FFFFF);
    bus_read(2'd2, 8'hC5, "R8 C mixed low driven");

    bus_write(2'd3, 8'h81);
    check("R3 C high out low in", pin_oe, 24'hF0FFFF);
    bus_read(2'd2, 8'hA3, "R8 C mixed high driven");

    bus_write(2'd3, 8'h90);
    check("R3 bit4 sets A", pin_oe, 24'hFFFF00);
    bus_write(2'd3, 8'h82);
    check("R3 bit1 sets B", pin_oe, 24'hFF00FF);

    bus_write(2'd3, 8'h9B);
    ext[7:0] = 8'h3C;
    bus_read(2'd0, 8'h3C, "R6 live sample 1");
    ext[7:0] = 8'hE1;
    bus_read(2'd0, 8'hE1, "R6 live sample 2");

    repeat (3) @(negedge clk);
    check("R6 scoreboard drained", PW'(exp_q.size()), '0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule